// File: doc/BRIEF.md
# Trace Port Sample Packer

This block takes one narrow trace-port sample per clock and packs successive samples into 32-bit words ready to be written into a trace RAM. Each sample has a 3-bit pipeline status, a packet field, and a sync flag. The packet field is 4, 8 or 16 bits wide, depending on the selected port width. A narrower port fits more samples into one word: three samples at 4 bits, two at 8 bits, one at 16 bits. Whatever the RAM writer receives is already in final storage layout.

A trigger is marked inside the data stream rather than on a side channel. On a trigger sample, a reserved status code takes the place of the pipeline status, and the real status moves into the bottom of the packet field.

When capture is switched off with a word part-filled, the partial word is pushed out with its unused slots zeroed. A port configuration the block cannot store is flagged, and its samples are dropped.

Top module: `trace_sample_packer`

## Requirements
- R1: With `width_sel`=00 (4-bit port), each slot is 8 bits: status in [2:0], packet[3:0] in [6:3] and sync in [7]. Three slots fill one word at bits [7:0], [15:8] and [23:16], in arrival order.
- R2: With `width_sel`=01 (8-bit port), each slot is 12 bits: status in [2:0], packet[7:0] in [10:3] and sync in [11]. Two slots fill one word at bits [11:0] and [23:12], in arrival order.
- R3: With `width_sel`=10 (16-bit port), every accepted sample yields one word: status in [2:0], packet in [18:3] and sync in [19].
- R4: When `smp_trig` is high, the status field of the slot holds `TRIG_CODE` (default 3'b110). The slot's packet bits [2:0] then hold the sample's real status, and its higher packet bits are kept.
- R5: Word bits above the last slot are zero: [31:24] for the 4-bit and 8-bit ports, and [31:20] for the 16-bit port.
- R6: `cfg_err` is high, and samples are ignored, in any of these cases:
  - `port_mode` is 01 (multiplexed) or 11;
  - `width_sel` is 11;
  - `port_mode` is 10 (demultiplexed) with a width other than 8-bit.

  `port_mode` 00 is the normal mode, and 10 with `width_sel`=01 is legal.
- R7: When `cap_en` is low and a partial word is pending, that word is emitted on the next edge with its empty slots zero. `empty_o` is high whenever no slot is filled.
- R8: A change of `width_sel`, or a rising `cap_en`, discards any partial word. The sample presented in that cycle then goes into slot 0.
- R9: After reset, `word_vld` is 0 and `empty_o` is 1.
- R10: `word_vld` is a one-cycle pulse, registered on the clock edge that accepts the last slot of a word (or performs a flush). With `cap_en` low and nothing pending, no word is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable |
| width_sel | input | 2 | Port width: 00=4, 01=8, 10=16 bits |
| port_mode | input | 2 | 00 normal, 01 multiplexed, 10 demultiplexed |
| smp_pstat | input | 3 | Sample pipeline status |
| smp_pkt | input | 16 | Sample packet field (low bits used on narrow ports) |
| smp_sync | input | 1 | Sample sync flag |
| smp_trig | input | 1 | Trigger marker for this sample |
| word_o | output | 32 | Packed word |
| word_vld | output | 1 | Word strobe |
| empty_o | output | 1 | No partial word pending |
| cfg_err | output | 1 | Unsupported port configuration |

## Verification
Each port width is fed distinct non-zero values in every slot, so that a slot in the wrong position, a wrong field order or a wrong slot count shows up as a changed word. Trigger samples are placed in different slot positions, so the substitution is seen apart from the packing. Sequences that toggle enable, switch width mid-word or present illegal modes separate the flush, discard and reject behaviours from one another.

// File: rtl/trace_sample_packer.sv
module trace_sample_packer #(
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [1:0]  width_sel,
  input  logic [1:0]  port_mode,
  input  logic [2:0]  smp_pstat,
  input  logic [15:0] smp_pkt,
  input  logic        smp_sync,
  input  logic        smp_trig,
  output logic [31:0] word_o,
  output logic        word_vld,
  output logic        empty_o,
  output logic        cfg_err
);
  localparam int ACC_W = 24;

  logic [ACC_W-1:0] acc, merged, slot;
  logic [1:0]  idx, base, width_q;
  logic        cap_q, accept, restart, last;
  logic [4:0]  sh;
  logic [2:0]  pst_f;
  logic [15:0] pkt_f;

  assign cfg_err = (port_mode == 2'b01) || (port_mode == 2'b11) || (width_sel == 2'b11) ||
                   (port_mode == 2'b10 && width_sel != 2'b01);
  assign accept  = cap_en && !cfg_err;
  assign restart = (width_sel != width_q) || (cap_en && !cap_q);
  assign base    = restart ? 2'd0 : idx;
  assign pst_f   = smp_trig ? TRIG_CODE : smp_pstat;
  assign pkt_f   = smp_trig ? {smp_pkt[15:3], smp_pstat} : smp_pkt;
  assign empty_o = (idx == 2'd0);

  always_comb begin
    case (width_sel)
      2'b00: begin
        slot = {16'b0, smp_sync, pkt_f[3:0], pst_f};
        sh   = {base, 3'b000};
        last = (base == 2'd2);
      end
      2'b01: begin
        slot = {12'b0, smp_sync, pkt_f[7:0], pst_f};
        sh   = 5'(base) * 5'd12;
        last = (base == 2'd1);
      end
      default: begin
        slot = {4'b0, smp_sync, pkt_f, pst_f};
        sh   = 5'd0;
        last = 1'b1;
      end
    endcase
    merged = ((base == 2'd0) ? '0 : acc) | (slot << sh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; idx <= '0; width_q <= 2'b00; cap_q <= 1'b0;
      word_o <= '0; word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      cap_q    <= cap_en;
      width_q  <= width_sel;
      if (!cap_en) begin
        if (idx != 2'd0) begin
          word_o   <= {8'b0, acc};
          word_vld <= 1'b1;
        end
        idx <= '0; acc <= '0;
      end else if (accept) begin
        if (last) begin
          word_o   <= {8'b0, merged};
          word_vld <= 1'b1;
          idx <= '0; acc <= '0;
        end else begin
          acc <= merged;
          idx <= base + 2'd1;
        end
      end else if (restart) begin
        idx <= '0; acc <= '0;
      end
    end
  end

  p_w16_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !cfg_err && width_sel == 2'b10) |=> word_vld);
  p_trig_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !cfg_err && width_sel == 2'b10 && smp_trig) |=>
      (word_o[2:0] == TRIG_CODE && word_o[5:3] == $past(smp_pstat)));
  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cfg_err && empty_o) |=> (!word_vld && empty_o));
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !empty_o) |=> (word_vld && empty_o));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && empty_o) |=> !word_vld);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !cap_en) |=> !word_vld);
endmodule

// File: tb/trace_sample_packer_bench.sv
module trace_sample_packer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_en = 1'b0, smp_sync = 1'b0, smp_trig = 1'b0;
  logic [1:0] width_sel = 2'b00, port_mode = 2'b00;
  logic [2:0] smp_pstat = '0;
  logic [15:0] smp_pkt = '0;
  logic [31:0] word_o;
  logic word_vld, empty_o, cfg_err;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trace_sample_packer u_trace_sample_packer (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .width_sel(width_sel), .port_mode(port_mode),
    .smp_pstat(smp_pstat), .smp_pkt(smp_pkt), .smp_sync(smp_sync), .smp_trig(smp_trig),
    .word_o(word_o), .word_vld(word_vld), .empty_o(empty_o), .cfg_err(cfg_err));

  typedef struct packed {
    logic [3:0] req; logic cap; logic [1:0] w; logic [1:0] md; logic trig; logic sync;
    logic [2:0] pst; logic [15:0] pkt; logic vld; logic [31:0] word;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R1: three 4-bit slots
    '{4'd1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 16'h0005, 1'b0, 32'h0},
    '{4'd1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 3'd2, 16'h000A, 1'b0, 32'h0},
    '{4'd1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd7, 16'h0003, 1'b1, 32'h001FD229},
    // R4: trigger in 4-bit slot 0
    '{4'd4, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 3'd4, 16'h000F, 1'b0, 32'h0},
    '{4'd4, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 32'h0},
    '{4'd4, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 32'h00000066},
    // R2 and R4: 8-bit slots, trigger in slot 1
    '{4'd2, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 3'd3, 16'h00A5, 1'b0, 32'h0},
    '{4'd2, 1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 3'd5, 16'h003C, 1'b1, 32'h001EED2B},
    // R3 and R5: 16-bit words, upper bits zero
    '{4'd3, 1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 3'd2, 16'h1234, 1'b1, 32'h000891A2},
    '{4'd4, 1'b1, 2'd2, 2'd0, 1'b1, 1'b0, 3'd1, 16'hFFFF, 1'b1, 32'h0007FFCE},
    // R6: demultiplexed with 8-bit is legal
    '{4'd6, 1'b1, 2'd1, 2'd2, 1'b0, 1'b0, 3'd1, 16'h0001, 1'b0, 32'h0},
    '{4'd6, 1'b1, 2'd1, 2'd2, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 32'h00000009},
    // R6: rejected configurations
    '{4'd6, 1'b1, 2'd1, 2'd1, 1'b0, 1'b1, 3'd7, 16'hFFFF, 1'b0, 32'h0},
    '{4'd6, 1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 3'd7, 16'hFFFF, 1'b0, 32'h0},
    '{4'd6, 1'b1, 2'd2, 2'd2, 1'b0, 1'b1, 3'd7, 16'hFFFF, 1'b0, 32'h0},
    '{4'd3, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 3'd3, 16'h0000, 1'b1, 32'h00000003}
  };

  task automatic drive(input logic c, input logic [1:0] w, input logic [1:0] md, input logic t,
                       input logic s, input logic [2:0] p, input logic [15:0] k);
    cap_en = c; width_sel = w; port_mode = md; smp_trig = t; smp_sync = s;
    smp_pstat = p; smp_pkt = k;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 word_vld after reset", 32'(word_vld), 32'd0);
    chk("R9 empty_o after reset", 32'(empty_o), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cap, VEC[i].w, VEC[i].md, VEC[i].trig, VEC[i].sync, VEC[i].pst, VEC[i].pkt);
      chk($sformatf("R%0d vec %0d vld", VEC[i].req, i), 32'(word_vld), 32'(VEC[i].vld));
      if (VEC[i].vld) chk($sformatf("R%0d vec %0d word", VEC[i].req, i), word_o, VEC[i].word);
    end

    drive(1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 3'd0, 16'h0);
    chk("R10 idle no word", 32'(word_vld), 32'd0);

    // R7: flush of a single filled 4-bit slot
    drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 16'h0002);
    chk("R7 pending not empty", 32'(empty_o), 32'd0);
    drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 3'd7, 16'hFFFF);
    chk("R7 flush vld", 32'(word_vld), 32'd1);
    chk("R7 flush word", word_o, 32'h00000011);
    chk("R7 empty after flush", 32'(empty_o), 32'd1);
    drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 16'h0);
    chk("R10 single pulse", 32'(word_vld), 32'd0);

    // R8: width change discards partial word
    drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 16'h0000);
    drive(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd2, 16'h0000);
    drive(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 3'd3, 16'h0000);
    chk("R8 no word on width change", 32'(word_vld), 32'd0);
    drive(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 3'd4, 16'h0000);
    chk("R8 vld after restart", 32'(word_vld), 32'd1);
    chk("R8 word after restart", word_o, 32'h00004003);

    // R6: rejected samples leave nothing pending
    drive(1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 3'd5, 16'h000F);
    chk("R6 cfg_err mux", 32'(cfg_err), 32'd1);
    chk("R6 nothing stored", 32'(empty_o), 32'd1);
    drive(1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 3'd0, 16'h0);
    chk("R6 cfg_err width 11", 32'(cfg_err), 32'd1);
    chk("R6 no word", 32'(word_vld), 32'd0);
    drive(1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 3'd0, 16'h0);
    chk("R6 demux 8-bit legal", 32'(cfg_err), 32'd0);
    chk("R5 upper zero last word", 32'(word_o[31:24]), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule